// File: doc/BRIEF.md
# PTP Timestamp Capture FIFO

This block keeps the hardware timestamps of PTP event frames until host software collects them. Each port has two lanes, one for transmitted and one for received frames. Each lane is a first-in first-out store of complete timestamp records. A record holds a message tag, a 48-bit seconds value, a 32-bit nanoseconds value, the 64-bit source clock identity, the 16-bit source port number and the 16-bit sequence ID.

The capture side pushes a whole record in one cycle. The host reads a record back as twelve 16-bit words, all through one data port. Each read consumes one word. When the last word of a record is read, the record leaves the store.

For each lane, a status word reports three things: the lane's capture enable, how far the host has got through the current record, and how many captures were lost because the store was full. A shared vector carries one not-empty flag per lane. Frame parsing and the time-of-day counter sit outside this block.

Top module: `ts_capture_fifo`

## Requirements
- R1: After reset, every lane is empty. `buf_ne` is all zero, and every status word shows read position 0 and discard count 0.
- R2: A capture pulse on a lane is stored only while that lane's `cap_enable` bit is 1. A capture while the bit is 0 changes neither the lane's contents nor its discard count.
- R3: A record is read out in twelve words, in this order: tag (1 word), seconds (3 words), nanoseconds (2 words), clock identity (4 words), port number (1 word), sequence ID (1 word). Multi-word fields come out most significant word first. `rd_data` shows the word at the current read position of the lane that `rd_chan` selects.
- R4: Each `rd_en` cycle on a non-empty lane advances its read position by one. After position 11 the position returns to 0, the record is removed, and the next record becomes visible.
- R5: A read of an empty lane shows `rd_data` = 0 and leaves the read position at its value.
- R6: A lane holds at most DEPTH (default 90) records. An enabled capture that arrives while the lane is full, with no pop in the same cycle, is dropped. The discard count then rises by one and saturates at 15.
- R7: When a capture and the pop of the last word hit the same lane in the same cycle, both take effect, even when the lane is full. Nothing is counted as discarded.
- R8: `stat_word` for the lane that `stat_chan` selects has this layout: bit 15 = capture enable, bits 12:8 = read position, bits 7:4 = discard count. All other bits are 0.
- R9: `buf_ne` bit i is 1 exactly when lane i holds at least one record. Lanes 0..NPORT-1 are transmit ports 1..NPORT, so transmit uses bits 0-2 by default. Lanes NPORT..2*NPORT-1 are receive ports 1..NPORT, so receive uses bits 3-5.
- R10: Lanes are independent. Captures, reads and drops on one lane never change another lane.
- R11: Within a lane, records come out in the order they were captured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_enable | input | 2*NPORT | Per-lane capture enable |
| cap_valid | input | 2*NPORT | Per-lane capture pulse |
| cap_rec | input | 2*NPORT*192 | Records; lane i occupies bits [192*i +: 192], with the tag in the top 16 bits |
| rd_en | input | 1 | Consume one word from the selected lane |
| rd_chan | input | clog2(2*NPORT) | Lane selected for reading |
| rd_data | output | 16 | Current word of the selected lane |
| stat_chan | input | clog2(2*NPORT) | Lane selected for status |
| stat_word | output | 16 | Status of the selected lane |
| buf_ne | output | 2*NPORT | Per-lane not-empty flags |

## Verification
The hardest condition to reach is a full lane that takes a capture in the same cycle as the final-word pop. This case must neither drop the capture nor count a discard.

The stimulus builds that state directly. It fills one transmit lane to its depth and pushes twenty more captures, which drives the discard count into saturation. It then reads eleven words and asserts a capture together with the twelfth read. Finally it drains the lane, counting records, while a behavioural queue model is compared every cycle. A long random phase then mixes captures, reads, enables and selections across all lanes.

// File: rtl/tscap_pkg.sv
package tscap_pkg;
  localparam int WORD_W    = 16;
  localparam int REC_WORDS = 12;
  localparam int REC_W     = WORD_W * REC_WORDS;
  localparam int RPOS_W    = 5;
  localparam int DISC_W    = 4;

  typedef struct packed {
    logic [15:0] tag;
    logic [47:0] secs;
    logic [31:0] nsecs;
    logic [63:0] clk_id;
    logic [15:0] src_port;
    logic [15:0] seq_id;
  } ts_rec_t;

  // word idx of a record, tag word first, high halves first
  function automatic logic [WORD_W-1:0] rec_word(ts_rec_t r, logic [RPOS_W-1:0] idx);
    logic [REC_W-1:0] flat;
    int sh;
    flat = r;
    if (int'(idx) >= REC_WORDS) return '0;
    sh = WORD_W * (REC_WORDS - 1 - int'(idx));
    return WORD_W'(flat >> sh);
  endfunction

  function automatic logic [DISC_W-1:0] disc_bump(logic [DISC_W-1:0] d);
    return (&d) ? d : d + 1'b1;
  endfunction

  function automatic logic [15:0] stat_pack(logic en, logic [RPOS_W-1:0] rp,
                                            logic [DISC_W-1:0] dc);
    return {en, 2'b00, rp, dc, 4'b0000};
  endfunction
endpackage

// File: rtl/ts_rec_store.sv
module ts_rec_store
  import tscap_pkg::*;
#(
  parameter int DEPTH = 90
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    push,
  input  ts_rec_t rec_in,
  input  logic    pop,
  output ts_rec_t head,
  output logic    full,
  output logic    empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  ts_rec_t          mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] ptr_next(logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= rec_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push) wptr <= ptr_next(wptr);
      if (pop)  rptr <= ptr_next(rptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rptr];
  assign full  = (count == FULL_CNT);
  assign empty = (count == '0);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL_CNT);
  assert_push_room_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (push && count == FULL_CNT) |-> pop);
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
endmodule

// File: rtl/ts_lane.sv
module ts_lane
  import tscap_pkg::*;
#(
  parameter int DEPTH = 90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cap_valid,
  input  ts_rec_t           cap_rec,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_word,
  output logic [15:0]       status,
  output logic              not_empty
);
  localparam logic [RPOS_W-1:0] LAST_POS = RPOS_W'(REC_WORDS - 1);

  ts_rec_t           head;
  logic              full, empty;
  logic [RPOS_W-1:0] rpos;
  logic [DISC_W-1:0] disc;

  // named events for the assertions
  logic rd_hit, pop_ev, cap_ev, push_ev, drop_ev;
  assign rd_hit  = rd_req & ~empty;
  assign pop_ev  = rd_hit & (rpos == LAST_POS);
  assign cap_ev  = cap_valid & enable;
  assign push_ev = cap_ev & (~full | pop_ev);
  assign drop_ev = cap_ev & full & ~pop_ev;

  ts_rec_store #(.DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .push   (push_ev),
    .rec_in (cap_rec),
    .pop    (pop_ev),
    .head   (head),
    .full   (full),
    .empty  (empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rpos <= '0;
      disc <= '0;
    end else begin
      if (rd_hit) rpos <= pop_ev ? '0 : rpos + 1'b1;
      if (drop_ev) disc <= disc_bump(disc);
    end
  end

  assign rd_word   = empty ? '0 : rec_word(head, rpos);
  assign status    = stat_pack(enable, rpos, disc);
  assign not_empty = ~empty;

  assert_rpos_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rpos <= LAST_POS);
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> $stable(rpos));
  assert_disc_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_ev && disc != '1) |=> (disc == $past(disc) + 1'b1));
  assert_disc_sat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (disc == '1) |=> (disc == '1));
  assert_disabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !rd_hit) |=> ($stable(not_empty) && $stable(disc)));
  assert_same_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_ev && pop_ev) |=> (not_empty && $stable(disc)));
endmodule

// File: rtl/ts_capture_fifo.sv
module ts_capture_fifo
  import tscap_pkg::*;
#(
  parameter int NPORT = 3,
  parameter int DEPTH = 90,
  localparam int NCH  = 2 * NPORT,
  localparam int CW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NCH-1:0]       cap_enable,
  input  logic [NCH-1:0]       cap_valid,
  input  logic [NCH*REC_W-1:0] cap_rec,
  input  logic                 rd_en,
  input  logic [CW-1:0]        rd_chan,
  output logic [WORD_W-1:0]    rd_data,
  input  logic [CW-1:0]        stat_chan,
  output logic [15:0]          stat_word,
  output logic [NCH-1:0]       buf_ne
);
  logic [WORD_W-1:0] lane_word [NCH];
  logic [15:0]       lane_stat [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_lane
    logic sel_rd;
    assign sel_rd = rd_en && (int'(rd_chan) == g);
    ts_lane #(.DEPTH(DEPTH)) u_lane (
      .clk       (clk),
      .rst_n     (rst_n),
      .enable    (cap_enable[g]),
      .cap_valid (cap_valid[g]),
      .cap_rec   (ts_rec_t'(cap_rec[g*REC_W +: REC_W])),
      .rd_req    (sel_rd),
      .rd_word   (lane_word[g]),
      .status    (lane_stat[g]),
      .not_empty (buf_ne[g])
    );
  end

  always_comb begin
    rd_data   = '0;
    stat_word = '0;
    for (int i = 0; i < NCH; i++) begin
      if (int'(rd_chan) == i)   rd_data   = lane_word[i];
      if (int'(stat_chan) == i) stat_word = lane_stat[i];
    end
  end

  assert_out_of_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(rd_chan) >= NCH) |-> (rd_data == '0));
endmodule

// File: tb/tb_ts_capture_fifo.sv
module tb_ts_capture_fifo;
  localparam int NP = 3, NCH = 6, DEPTH = 90, CW = 3, RW = 192, NW = 12;

  logic              clk = 0, rst_n = 0;
  logic [NCH-1:0]    cap_enable = '0, cap_valid = '0, buf_ne;
  logic [NCH*RW-1:0] cap_rec = '0;
  logic              rd_en = 0;
  logic [CW-1:0]     rd_chan = '0, stat_chan = '0;
  logic [15:0]       rd_data, stat_word;

  always #5 clk = ~clk;

  ts_capture_fifo #(.NPORT(NP), .DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .cap_enable(cap_enable), .cap_valid(cap_valid),
    .cap_rec(cap_rec), .rd_en(rd_en), .rd_chan(rd_chan), .rd_data(rd_data),
    .stat_chan(stat_chan), .stat_word(stat_word), .buf_ne(buf_ne));

  logic [RW-1:0] mq [NCH][$];
  int mpos [NCH];
  int mdisc [NCH];
  int total = 0, bad = 0;

  task automatic chk(string req, longint act, longint expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // word k of a record: tag, sec x3, nsec x2, clkid x4, port, seq
  function automatic logic [15:0] want_word(logic [RW-1:0] r, int k);
    logic [RW-1:0] t;
    t = r << (16 * k);
    return t[RW-1 -: 16];
  endfunction

  task automatic compare();
    logic [NCH-1:0] ne;
    logic [15:0] ew, es;
    int c;
    #1;
    for (int i = 0; i < NCH; i++) ne[i] = (mq[i].size() > 0);
    chk("R9 buf_ne", buf_ne, ne);
    c = rd_chan;
    ew = (c < NCH && mq[c].size() > 0) ? want_word(mq[c][0], mpos[c]) : 16'h0;
    chk("R3 rd_data", rd_data, ew);
    c = stat_chan;
    es = 16'h0;
    if (c < NCH) begin
      es[15] = cap_enable[c];
      es[12:8] = 5'(mpos[c]);
      es[7:4] = 4'(mdisc[c]);
    end
    chk("R8 stat_word", stat_word, es);
  endtask

  task automatic model_edge();
    for (int i = 0; i < NCH; i++) begin
      bit rd, pop, cap, wasfull;
      wasfull = (mq[i].size() == DEPTH);
      rd = rd_en && rd_chan == i && mq[i].size() > 0;
      pop = rd && mpos[i] == NW - 1;
      cap = cap_valid[i] && cap_enable[i];
      if (rd) mpos[i] = pop ? 0 : mpos[i] + 1;
      if (pop) void'(mq[i].pop_front());
      if (cap) begin
        if (wasfull && !pop) begin
          if (mdisc[i] < 15) mdisc[i]++;
        end else mq[i].push_back(cap_rec[i*RW +: RW]);
      end
    end
  endtask

  task automatic step();
    compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cap_valid = '0;
    rd_en = 0;
  endtask

  function automatic logic [RW-1:0] rnd_rec();
    return {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic put(int ch, logic [RW-1:0] r);
    cap_valid[ch] = 1'b1;
    cap_rec[ch*RW +: RW] = r;
    step();
  endtask

  task automatic rdw(int ch);
    rd_chan = CW'(ch);
    stat_chan = CW'(ch);
    rd_en = 1;
    step();
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    $display("FAIL watchdog: run did not finish");
    $display("test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [RW-1:0] ra, rb;
    int nrec;
    for (int i = 0; i < NCH; i++) begin mpos[i] = 0; mdisc[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 ne after reset", buf_ne, 0);
    chk("R1 status after reset", stat_word, 16'h0);

    // R2: disabled lane ignores capture
    cap_enable = 6'b111011;
    stat_chan = 2;
    put(2, rnd_rec());
    #1;
    chk("R2 disabled lane stays empty", buf_ne[2], 0);
    chk("R2 disabled lane discard", stat_word[7:4], 0);
    cap_enable = '1;

    // R11 / R3 / R4 / R10
    ra = rnd_rec(); rb = rnd_rec();
    put(0, ra); put(0, rb);
    put(3, rnd_rec());
    #1;
    chk("R10 other lanes untouched", buf_ne, 6'b001001);
    rd_chan = 0; #1;
    chk("R11 oldest first", rd_data, ra[191:176]);
    for (int k = 0; k < NW - 1; k++) rdw(0);
    #1;
    chk("R4 position at last word", stat_word[12:8], 11);
    chk("R3 sequence id last", rd_data, ra[15:0]);
    rdw(0);
    #1;
    chk("R4 wrap to zero", stat_word[12:8], 0);
    chk("R4 next record shown", rd_data, rb[191:176]);

    // R5: empty lane read
    rdw(4);
    #1;
    chk("R5 empty read data", rd_data, 0);
    chk("R5 empty read position", stat_word[12:8], 0);

    // R6: fill lane 1 and overflow
    for (int k = 0; k < DEPTH + 20; k++) put(1, rnd_rec());
    stat_chan = 1; #1;
    chk("R6 discard saturates", stat_word[7:4], 15);
    // R7: capture with final-word pop on a full lane
    for (int k = 0; k < NW - 1; k++) rdw(1);
    cap_valid[1] = 1'b1;
    cap_rec[RW +: RW] = rnd_rec();
    rdw(1);
    nrec = 0;
    while (buf_ne[1] && nrec < DEPTH + 5) begin
      for (int k = 0; k < NW; k++) rdw(1);
      nrec++;
      #1;
    end
    chk("R7 record count after same-cycle push/pop", nrec, DEPTH);
    chk("R7 discard unchanged", stat_word[7:4], 15);

    // random mix, all lanes
    for (int n = 0; n < 4000; n++) begin
      cap_enable = NCH'($urandom);
      cap_enable = cap_enable | NCH'($urandom);
      cap_valid = NCH'($urandom) & NCH'($urandom);
      for (int i = 0; i < NCH; i++) cap_rec[i*RW +: RW] = rnd_rec();
      rd_en = $urandom_range(0, 3) != 0;
      rd_chan = CW'($urandom_range(0, 7));
      stat_chan = CW'($urandom_range(0, 7));
      step();
    end
    compare();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule